// File: doc/BRIEF.md
# Audio Codec Power and Reset Sequencer

This block is the digital control slice that decides which converter paths of an audio codec are live. A host writes two 8-bit control registers over a simple write port: a power register and a run/reset register. From their bits the block drives enables for the voltage reference, the ADC path and the DAC path. The value of each register can be read back at all times.

When the DAC path is down or held in reset, both channels' current output attenuation levels are forced to zero. Once the path is running again, each level climbs back toward its channel's target attenuation value, one step per audio frame, so the output never jumps. When the ADC path is down or in reset, the serial ADC data output is held low. After the path comes back, it stays at zero for a fixed number of frames before samples pass through. Frames are counted on rising edges of the frame clock, which arrives asynchronously and is synchronized inside the block. Register contents survive every power and reset state.

Top module: `codec_pwr_seq`

## Requirements
- R1: After `rst`, the power register reads 0x07 and the run register reads 0x00. In the power register, bit 0 is DAC power, bit 1 is ADC power and bit 2 is reference power, and bits 7..3 always read 0. In the run register, bit 0 is DAC run and bit 1 is ADC run, bits 3..2 always read 0, and bits 7..4 are stored test bits with no effect on any output.
- R2: `vref_en` equals power bit 2. `adc_en` is power bit 2 AND power bit 1 AND run bit 1. `dac_en` is power bit 2 AND power bit 0 AND run bit 0. Each enable follows a register write in the cycle after the write edge.
- R3: On the first clock edge at which `dac_en` is 0, both `att_l` and `att_r` become 0x00. They stay 0x00 while `dac_en` is 0.
- R4: While `dac_en` is 1, each attenuation level moves exactly one step toward its target (`att_tgt_l`/`att_tgt_r`) per frame tick, up or down. A target rewritten mid-ramp is followed from the current level.
- R5: While `adc_en` is 0, `adc_sdata_out` is 0 in the same cycle, with no clock delay.
- R6: After `adc_en` rises, `adc_sdata_out` is 0 for the first 516 frame ticks. From the 516th tick on, it equals `adc_sdata_in`.
- R7: If `adc_en` falls before the 516-tick count ends, the count restarts from zero at the next rise.
- R8: Both registers keep their contents in every power/run state. They are written only when `reg_we` is 1, and writes are accepted in any state.
- R9: A frame tick is one system-clock cycle produced for each rising edge of `lrck`, after a two-flop synchronizer. It causes at most one ramp step and one count per `lrck` period.
- R10: A synchronous active-high `rst` restores both register defaults and clears the ramp levels, the frame counter and the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects power register, 1 selects run register |
| reg_wdata | input | 8 | Write data |
| pwr_rd | output | 8 | Power register read value |
| run_rd | output | 8 | Run register read value |
| lrck | input | 1 | Asynchronous frame clock |
| att_tgt_l | input | 8 | Left target attenuation level |
| att_tgt_r | input | 8 | Right target attenuation level |
| adc_sdata_in | input | 1 | Serial ADC data from the converter |
| adc_sdata_out | output | 1 | Serial ADC data after mute gating |
| vref_en | output | 1 | Reference enable |
| adc_en | output | 1 | ADC path enable |
| dac_en | output | 1 | DAC path enable |
| att_l | output | 8 | Current left attenuation level |
| att_r | output | 8 | Current right attenuation level |

## Verification
The checker looks at every cycle. It confirms that the reference bit gates both converter enables and that a down DAC path zeroes both levels on the next edge. It confirms that levels never move by more than one step per cycle while running, that a down ADC path silences the data output combinationally, and that registers hold without a write strobe. The length of the 516-frame silence, its restart after an interrupted count, and the ramp's exact frame-by-frame values depend on the frame clock's history. Only the bench's timed scenarios show those, along with the downward follow of a rewritten target and the inertness of the test bits.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

    localparam int REG_W       = 8;
    localparam int ATT_W       = 8;
    localparam int MUTE_FRAMES = 516;
    localparam int NUM_CH      = 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        SEL_PWR = 1'b0,
        SEL_RUN = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic ref_up;
        logic adc_up;
        logic dac_up;
    } pwr_bits_t;

    typedef struct packed {
        logic [3:0] test;
        logic       adc_run;
        logic       dac_run;
    } run_bits_t;

    typedef struct packed {
        logic vref;
        logic adc;
        logic dac;
    } path_en_t;

    localparam pwr_bits_t PWR_DEFAULT = '{ref_up: 1'b1, adc_up: 1'b1, dac_up: 1'b1};
    localparam run_bits_t RUN_DEFAULT = '{test: 4'h0, adc_run: 1'b0, dac_run: 1'b0};

    function automatic logic [REG_W-1:0] pwr_to_bus(pwr_bits_t p);
        return {5'b0, p.ref_up, p.adc_up, p.dac_up};
    endfunction

    function automatic logic [REG_W-1:0] run_to_bus(run_bits_t r);
        return {r.test, 2'b00, r.adc_run, r.dac_run};
    endfunction

    function automatic path_en_t derive_en(pwr_bits_t p, run_bits_t r);
        path_en_t e;
        e.vref = p.ref_up;
        e.adc  = p.ref_up & p.adc_up & r.adc_run;
        e.dac  = p.ref_up & p.dac_up & r.dac_run;
        return e;
    endfunction

    function automatic logic [ATT_W-1:0] step_toward(logic [ATT_W-1:0] cur,
                                                     logic [ATT_W-1:0] tgt);
        if (cur < tgt)      return cur + ATT_W'(1);
        else if (cur > tgt) return cur - ATT_W'(1);
        else                return cur;
    endfunction

endpackage

// File: rtl/codec_ctl_regs.sv
module codec_ctl_regs
    import codec_pwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output pwr_bits_t        pwr_q,
    output run_bits_t        run_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q <= PWR_DEFAULT;
            run_q <= RUN_DEFAULT;
        end else if (we) begin
            if (reg_sel_e'(sel) == SEL_PWR) begin
                pwr_q <= '{ref_up: wdata[2], adc_up: wdata[1], dac_up: wdata[0]};
            end else begin
                run_q <= '{test: wdata[7:4], adc_run: wdata[1], dac_run: wdata[0]};
            end
        end
    end

endmodule

// File: rtl/codec_lrck_sync.sv
module codec_lrck_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic lrck_async,
    output logic frame_tick
);

    logic [STAGES-1:0] chain;
    logic              last;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= lrck_async;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= 1'b0;
            else     chain[i] <= chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last <= 1'b0;
        else     last <= chain[STAGES-1];
    end

    assign frame_tick = chain[STAGES-1] & ~last;

endmodule

// File: rtl/codec_adc_gate.sv
module codec_adc_gate #(
    parameter int MUTE_FRAMES = 516
) (
    input  logic clk,
    input  logic rst,
    input  logic adc_en,
    input  logic frame_tick,
    input  logic sdata_in,
    output logic sdata_out
);

    localparam int CNT_W = $clog2(MUTE_FRAMES + 1);
    localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(MUTE_FRAMES);

    logic [CNT_W-1:0] cnt;
    logic             done;

    assign done = (cnt == CNT_DONE);

    always_ff @(posedge clk) begin
        if (rst || !adc_en) cnt <= '0;
        else if (frame_tick && !done) cnt <= cnt + CNT_W'(1);
    end

    assign sdata_out = sdata_in & adc_en & done;

endmodule

// File: rtl/codec_att_ramp.sv
module codec_att_ramp
    import codec_pwr_pkg::*;
#(
    parameter int W = ATT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dac_en,
    input  logic         frame_tick,
    input  logic [W-1:0] target,
    output logic [W-1:0] level
);

    always_ff @(posedge clk) begin
        if (rst || !dac_en) level <= '0;
        else if (frame_tick) level <= step_toward(level, target);
    end

endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int MUTE_LEN = MUTE_FRAMES,
    parameter int SYNC_N   = SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] pwr_rd,
    output logic [REG_W-1:0] run_rd,
    input  logic             lrck,
    input  logic [ATT_W-1:0] att_tgt_l,
    input  logic [ATT_W-1:0] att_tgt_r,
    input  logic             adc_sdata_in,
    output logic             adc_sdata_out,
    output logic             vref_en,
    output logic             adc_en,
    output logic             dac_en,
    output logic [ATT_W-1:0] att_l,
    output logic [ATT_W-1:0] att_r
);

    pwr_bits_t        pwr_q;
    run_bits_t        run_q;
    path_en_t         en;
    logic             frame_tick;
    logic [ATT_W-1:0] tgt   [NUM_CH];
    logic [ATT_W-1:0] level [NUM_CH];

    codec_ctl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .sel   (reg_sel),
        .wdata (reg_wdata),
        .pwr_q (pwr_q),
        .run_q (run_q)
    );

    assign pwr_rd  = pwr_to_bus(pwr_q);
    assign run_rd  = run_to_bus(run_q);
    assign en      = derive_en(pwr_q, run_q);
    assign vref_en = en.vref;
    assign adc_en  = en.adc;
    assign dac_en  = en.dac;

    codec_lrck_sync #(.STAGES(SYNC_N)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .lrck_async (lrck),
        .frame_tick (frame_tick)
    );

    codec_adc_gate #(.MUTE_FRAMES(MUTE_LEN)) u_adc (
        .clk        (clk),
        .rst        (rst),
        .adc_en     (en.adc),
        .frame_tick (frame_tick),
        .sdata_in   (adc_sdata_in),
        .sdata_out  (adc_sdata_out)
    );

    assign tgt[0] = att_tgt_l;
    assign tgt[1] = att_tgt_r;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        codec_att_ramp #(.W(ATT_W)) u_ramp (
            .clk        (clk),
            .rst        (rst),
            .dac_en     (en.dac),
            .frame_tick (frame_tick),
            .target     (tgt[c]),
            .level      (level[c])
        );
    end

    assign att_l = level[0];
    assign att_r = level[1];

endmodule

// File: rtl/codec_pwr_seq_chk.sv
module codec_pwr_seq_chk
    import codec_pwr_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             reg_we,
    input logic [REG_W-1:0] pwr_rd,
    input logic [REG_W-1:0] run_rd,
    input logic             vref_en,
    input logic             adc_en,
    input logic             dac_en,
    input logic             adc_sdata_out,
    input logic [ATT_W-1:0] att_l,
    input logic [ATT_W-1:0] att_r
);

    AST_VREF_GATES_PATHS: assert property (@(posedge clk) disable iff (rst)
        !vref_en |-> (!adc_en && !dac_en)); // R2

    AST_DAC_DOWN_ZERO: assert property (@(posedge clk) disable iff (rst)
        !dac_en |=> (att_l == '0 && att_r == '0)); // R3

    AST_RAMP_STEP_L: assert property (@(posedge clk) disable iff (rst)
        dac_en |=> (att_l == $past(att_l) || att_l == $past(att_l) + ATT_W'(1)
                    || att_l == $past(att_l) - ATT_W'(1))); // R4

    AST_RAMP_STEP_R: assert property (@(posedge clk) disable iff (rst)
        dac_en |=> (att_r == $past(att_r) || att_r == $past(att_r) + ATT_W'(1)
                    || att_r == $past(att_r) - ATT_W'(1))); // R4

    AST_ADC_DOWN_LOW: assert property (@(posedge clk) disable iff (rst)
        !adc_en |-> !adc_sdata_out); // R5

    AST_ADC_RISE_MUTED: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_en) |-> !adc_sdata_out); // R6

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_we |=> ($stable(pwr_rd) && $stable(run_rd))); // R8

endmodule

bind codec_pwr_seq codec_pwr_seq_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_we        (reg_we),
    .pwr_rd        (pwr_rd),
    .run_rd        (run_rd),
    .vref_en       (vref_en),
    .adc_en        (adc_en),
    .dac_en        (dac_en),
    .adc_sdata_out (adc_sdata_out),
    .att_l         (att_l),
    .att_r         (att_r)
);

// File: tb/sim_codec_pwr_seq.sv
module sim_codec_pwr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LR_HALF    = 4;
    localparam int MUTE       = 516;

    localparam int S_PWR = 0, S_RUN = 1, S_VREF = 2, S_ADC = 3,
                   S_DAC = 4, S_ATTL = 5, S_ATTR = 6, S_SOUT = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] pwr_rd, run_rd;
    logic       lrck = 1'b0;
    logic [7:0] att_tgt_l = 8'd0;
    logic [7:0] att_tgt_r = 8'd0;
    logic       adc_sdata_in = 1'b0;
    logic       adc_sdata_out, vref_en, adc_en, dac_en;
    logic [7:0] att_l, att_r;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        string      req;
        int         sig;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];

    codec_pwr_seq u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .pwr_rd(pwr_rd), .run_rd(run_rd),
        .lrck(lrck), .att_tgt_l(att_tgt_l), .att_tgt_r(att_tgt_r),
        .adc_sdata_in(adc_sdata_in), .adc_sdata_out(adc_sdata_out),
        .vref_en(vref_en), .adc_en(adc_en), .dac_en(dac_en),
        .att_l(att_l), .att_r(att_r)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        forever begin
            repeat (LR_HALF) @(posedge clk);
            #1 lrck = ~lrck;
        end
    end

    function automatic logic [7:0] actual(int sig);
        case (sig)
            S_PWR:  return pwr_rd;
            S_RUN:  return run_rd;
            S_VREF: return {7'd0, vref_en};
            S_ADC:  return {7'd0, adc_en};
            S_DAC:  return {7'd0, dac_en};
            S_ATTL: return att_l;
            S_ATTR: return att_r;
            default: return {7'd0, adc_sdata_out};
        endcase
    endfunction

    // monitor: compares queued expectations half a cycle after they are pushed
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] a;
            it = sb_q.pop_front();
            a = actual(it.sig);
            checks++;
            if (a !== it.exp) begin
                errors++;
                $display("FAIL %s sig%0d actual=%0h expected=%0h", it.req, it.sig, a, it.exp);
            end
        end
    end

    task automatic expect_v(string req, int sig, logic [7:0] exp);
        item_t it;
        it.req = req; it.sig = sig; it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic wr(logic sel, logic [7:0] d);
        reg_sel = sel; reg_wdata = d; reg_we = 1'b1;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // returns past the synchronized tick of the next lrck rise
    task automatic frame();
        @(posedge lrck);
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic frames(int n);
        for (int i = 0; i < n; i++) frame();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst = 1'b0;
        cyc(1);
        // R1 / R10 reset state
        expect_v("R1", S_PWR, 8'h07);
        expect_v("R1", S_RUN, 8'h00);
        expect_v("R10", S_ATTL, 8'h00);
        expect_v("R10", S_SOUT, 8'h00);
        expect_v("R2", S_VREF, 8'h01);
        expect_v("R2", S_DAC, 8'h00);
        cyc(1);

        wr(1'b0, 8'hFF);
        expect_v("R1", S_PWR, 8'h07);
        wr(1'b1, 8'hFC);
        expect_v("R1", S_RUN, 8'hF0);
        expect_v("R1", S_DAC, 8'h00);
        expect_v("R1", S_ADC, 8'h00);
        cyc(1);

        // DAC ramp: left target 3, right target 10
        att_tgt_l = 8'd3; att_tgt_r = 8'd10;
        frame();
        wr(1'b1, 8'h01);
        expect_v("R2", S_DAC, 8'h01);
        expect_v("R1", S_RUN, 8'h01);
        for (int k = 1; k <= 10; k++) begin
            frame();
            expect_v("R4", S_ATTL, 8'((k < 3) ? k : 3));
            expect_v("R9", S_ATTR, 8'(k));
        end
        att_tgt_r = 8'd7;
        frame();
        expect_v("R4", S_ATTR, 8'd9);
        frames(2);
        expect_v("R4", S_ATTR, 8'd7);
        frame();
        expect_v("R4", S_ATTR, 8'd7);

        // DAC power down
        wr(1'b0, 8'h06);
        expect_v("R2", S_DAC, 8'h00);
        cyc(1);
        expect_v("R3", S_ATTL, 8'h00);
        expect_v("R3", S_ATTR, 8'h00);
        expect_v("R8", S_RUN, 8'h01);
        frame();
        expect_v("R3", S_ATTR, 8'h00);
        wr(1'b0, 8'h07);
        frame();
        expect_v("R4", S_ATTL, 8'd1);
        expect_v("R4", S_ATTR, 8'd1);

        // reference off gates both paths
        wr(1'b1, 8'h03);
        wr(1'b0, 8'h03);
        expect_v("R2", S_VREF, 8'h00);
        expect_v("R2", S_ADC, 8'h00);
        expect_v("R2", S_DAC, 8'h00);
        expect_v("R8", S_RUN, 8'h03);

        // ADC mute window
        adc_sdata_in = 1'b1;
        frame();
        wr(1'b0, 8'h07);
        expect_v("R5", S_SOUT, 8'h00);
        expect_v("R2", S_ADC, 8'h01);
        frames(MUTE - 1);
        expect_v("R6", S_SOUT, 8'h00);
        frame();
        expect_v("R6", S_SOUT, 8'h01);
        wr(1'b1, 8'h01);
        expect_v("R5", S_SOUT, 8'h00);

        // interrupted count restarts
        wr(1'b1, 8'h03);
        frames(300);
        wr(1'b0, 8'h05);
        expect_v("R5", S_SOUT, 8'h00);
        wr(1'b0, 8'h07);
        frames(MUTE - 1);
        expect_v("R7", S_SOUT, 8'h00);
        frame();
        expect_v("R7", S_SOUT, 8'h01);

        // reset mid-operation
        rst = 1'b1;
        cyc(2);
        rst = 1'b0;
        expect_v("R10", S_PWR, 8'h07);
        expect_v("R10", S_RUN, 8'h00);
        expect_v("R10", S_ATTL, 8'h00);
        expect_v("R10", S_SOUT, 8'h00);
        cyc(2);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule